// File: doc/BRIEF.md
# Mirrored Playfield Line Serializer

This block draws a coarse background pattern across one 160-pixel raster line. Software writes three pattern registers, a control register and four colour registers through a simple write strobe. A horizontal position counter and a pixel-clock enable come from the raster timing. Each enabled pixel clock, the block turns the current position into one playfield bit. It picks the colour register that wins against the two player pixels supplied from outside, and registers the pixel, the colour select and the 8-bit colour value.

Each pattern bit is four pixels wide, so a half line carries 20 bits. The 20 bits are gathered from the three registers in mixed bit orders. The right half either repeats the left half or mirrors it. A score option recolours set pattern pixels with the player-0 colour on the left and the player-1 colour on the right. A priority option puts the pattern in front of the players.

The pixel stream is paced by the raster, not by a consumer. There is therefore no valid/ready pair. An output beat exists exactly in the cycle after a cycle with `pix_en` high, and back-pressure cannot be applied. Control and register pins are plain strobes.

Top module: `pf_line_serializer`

## Requirements
- R1: After reset, `pf_px` is 0, `col_sel` is 0 (background) and `color` is 0x00, and all registers read as zero.
- R2: One clock after a cycle with `pix_en` high and `hpos` below 80, `pf_px` shows pattern bit k = `hpos`/4. Bits k=0..3 are PF0 data bits 4..7, k=4..11 are PF1 bits 7 down to 0, and k=12..19 are PF2 bits 0..7.
- R3: With control bit 0 (reflect) clear, a position `hpos` in 80..159 shows the same bit as `hpos`-80.
- R4: With reflect set, a position in 80..159 shows bit 19-k, where k = (`hpos`-80)/4, so that the right half is the exact mirror of the left half.
- R5: With control bit 1 (score) set, a set pattern pixel that wins takes the player-0 colour (`col_sel`=2) on the left half and the player-1 colour (`col_sel`=3) on the right half. Otherwise it takes the playfield colour (`col_sel`=1).
- R6: With control bit 2 (priority) set, a set visible pattern pixel wins over both player pixels.
- R7: With priority clear, `p0_px` wins over `p1_px`, which wins over the pattern, which wins over the background (`col_sel`=0).
- R8: `color` equals bits 7..1 of the selected colour register with bit 0 forced to 0. Bit 0 of a written colour value has no effect. The register addresses are 0 PF0, 1 PF1, 2 PF2, 3 control, 4 background, 5 playfield, 6 player 0 and 7 player 1.
- R9: For `hpos` of 160 or more, `pf_px` is 0 and `col_sel` is background, whatever the player pixels are.
- R10: A register write takes effect on the next enabled pixel, including in the middle of a line.
- R11: While `pix_en` is low, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable |
| hpos | input | 8 | Horizontal pixel position |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| p0_px | input | 1 | Player-0 pixel at `hpos` |
| p1_px | input | 1 | Player-1 pixel at `hpos` |
| pf_px | output | 1 | Registered playfield pixel |
| col_sel | output | 2 | Winning colour source: 0 background, 1 playfield, 2 player 0, 3 player 1 |
| color | output | 8 | Registered colour value {hue, luminance, 0} |

## Verification
Priority resolution and score recolouring can land on the same pixel. This happens when a set pattern bit coincides with an active player pixel. The line sweeps therefore run with priority and score in all four combinations while player pixels toggle on unrelated periods. At each beat the expected source is judged from the requirement ordering, and the expected colour from the half of the line. A register write can also land between two pixels of the same line. Such writes are placed mid-line, and the very next beat is judged against the new value.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int PAT_BITS = 20;

  typedef enum logic [1:0] {
    SEL_BK = 2'd0,
    SEL_PF = 2'd1,
    SEL_P0 = 2'd2,
    SEL_P1 = 2'd3
  } col_sel_e;

  typedef enum logic [2:0] {
    A_PF0   = 3'd0,
    A_PF1   = 3'd1,
    A_PF2   = 3'd2,
    A_CTRL  = 3'd3,
    A_COLBK = 3'd4,
    A_COLPF = 3'd5,
    A_COLP0 = 3'd6,
    A_COLP1 = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic pri;
    logic score;
    logic refl;
  } ctrl_t;
endpackage

// File: rtl/pfs_regs.sv
module pfs_regs
  import pfs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [3:0]        pf0,
  output logic [7:0]        pf1,
  output logic [7:0]        pf2,
  output ctrl_t             ctrl,
  output logic [DATA_W-2:0] col_bk,
  output logic [DATA_W-2:0] col_pf,
  output logic [DATA_W-2:0] col_p0,
  output logic [DATA_W-2:0] col_p1
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf0    <= '0;
      pf1    <= '0;
      pf2    <= '0;
      ctrl   <= '0;
      col_bk <= '0;
      col_pf <= '0;
      col_p0 <= '0;
      col_p1 <= '0;
    end else if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        A_PF0:   pf0    <= wr_data[7:4];
        A_PF1:   pf1    <= wr_data[7:0];
        A_PF2:   pf2    <= wr_data[7:0];
        A_CTRL:  ctrl   <= '{pri: wr_data[2], score: wr_data[1], refl: wr_data[0]};
        A_COLBK: col_bk <= wr_data[DATA_W-1:1];
        A_COLPF: col_pf <= wr_data[DATA_W-1:1];
        A_COLP0: col_p0 <= wr_data[DATA_W-1:1];
        A_COLP1: col_p1 <= wr_data[DATA_W-1:1];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pfs_bit_sel.sv
module pfs_bit_sel
  import pfs_pkg::*;
#(
  parameter int HPOS_W   = 8,
  parameter int HALF_PIX = 80,
  parameter int BIT_PIX  = 4
) (
  input  logic [HPOS_W-1:0] hpos,
  input  logic [3:0]        pf0,
  input  logic [7:0]        pf1,
  input  logic [7:0]        pf2,
  input  logic              refl,
  output logic              visible,
  output logic              right_half,
  output logic              pf_on
);
  localparam int LINE_PIX = 2 * HALF_PIX;
  localparam int IDX_W    = $clog2(PAT_BITS);

  logic [PAT_BITS-1:0] seq;
  logic [HPOS_W-1:0]   offs;
  logic [HPOS_W-1:0]   idx_full;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    pick;

  // Left-half emission order: PF0 low-to-high, PF1 high-to-low, PF2 low-to-high
  for (genvar i = 0; i < PAT_BITS; i++) begin : g_seq
    if (i < 4) begin : g_a
      assign seq[i] = pf0[i];
    end else if (i < 12) begin : g_b
      assign seq[i] = pf1[11-i];
    end else begin : g_c
      assign seq[i] = pf2[i-12];
    end
  end

  always_comb begin
    visible    = hpos < HPOS_W'(LINE_PIX);
    right_half = hpos >= HPOS_W'(HALF_PIX);
    offs       = right_half ? hpos - HPOS_W'(HALF_PIX) : hpos;
    idx_full   = offs / HPOS_W'(BIT_PIX);
    idx        = idx_full[IDX_W-1:0];
    pick       = (right_half && refl) ? IDX_W'(PAT_BITS - 1) - idx : idx;
    pf_on      = visible && seq[pick];
  end
endmodule

// File: rtl/pfs_color_mux.sv
module pfs_color_mux
  import pfs_pkg::*;
(
  input  logic     visible,
  input  logic     right_half,
  input  logic     pf_on,
  input  ctrl_t    ctrl,
  input  logic     p0_px,
  input  logic     p1_px,
  output col_sel_e sel
);
  col_sel_e pf_src;

  always_comb begin
    pf_src = ctrl.score ? (right_half ? SEL_P1 : SEL_P0) : SEL_PF;
    if (!visible)                 sel = SEL_BK;
    else if (ctrl.pri && pf_on)   sel = pf_src;
    else if (p0_px)               sel = SEL_P0;
    else if (p1_px)               sel = SEL_P1;
    else if (pf_on)               sel = pf_src;
    else                          sel = SEL_BK;
  end
endmodule

// File: rtl/pf_line_serializer.sv
module pf_line_serializer
  import pfs_pkg::*;
#(
  parameter int HPOS_W   = 8,
  parameter int LINE_PIX = 160,
  parameter int COL_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [HPOS_W-1:0] hpos,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [COL_W-1:0] wr_data,
  input  logic             p0_px,
  input  logic             p1_px,
  output logic             pf_px,
  output logic [1:0]       col_sel,
  output logic [COL_W-1:0] color
);
  localparam int HALF_PIX = LINE_PIX / 2;
  localparam int BIT_PIX  = HALF_PIX / PAT_BITS;

  logic [3:0]       pf0;
  logic [7:0]       pf1, pf2;
  ctrl_t            ctrl;
  logic [COL_W-2:0] col_bk, col_pf, col_p0, col_p1;
  logic             visible, right_half, pf_on;
  col_sel_e         sel;
  logic [COL_W-2:0] col_pick;

  pfs_regs #(.DATA_W(COL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pf0(pf0), .pf1(pf1), .pf2(pf2), .ctrl(ctrl),
    .col_bk(col_bk), .col_pf(col_pf), .col_p0(col_p0), .col_p1(col_p1)
  );

  pfs_bit_sel #(.HPOS_W(HPOS_W), .HALF_PIX(HALF_PIX), .BIT_PIX(BIT_PIX)) u_bits (
    .hpos(hpos), .pf0(pf0), .pf1(pf1), .pf2(pf2), .refl(ctrl.refl),
    .visible(visible), .right_half(right_half), .pf_on(pf_on)
  );

  pfs_color_mux u_mux (
    .visible(visible), .right_half(right_half), .pf_on(pf_on), .ctrl(ctrl),
    .p0_px(p0_px), .p1_px(p1_px), .sel(sel)
  );

  always_comb begin
    unique case (sel)
      SEL_PF:  col_pick = col_pf;
      SEL_P0:  col_pick = col_p0;
      SEL_P1:  col_pick = col_p1;
      default: col_pick = col_bk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_px   <= 1'b0;
      col_sel <= SEL_BK;
      color   <= '0;
    end else if (pix_en) begin
      pf_px   <= pf_on;
      col_sel <= sel;
      color   <= {col_pick, 1'b0};
    end
  end

  AST_OFFSCREEN_BK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && (hpos >= HPOS_W'(LINE_PIX)) |=> !pf_px && (col_sel == SEL_BK)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pf_px) && $stable(col_sel) && $stable(color)); // R11

  AST_PF_IN_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && ctrl.pri && pf_on |=> pf_px && (col_sel != SEL_BK)); // R6

  AST_PLAYER_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && visible && !ctrl.pri && p0_px |=> col_sel == SEL_P0); // R7

  AST_COLOR_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_en) |=> !color[0]); // R8
endmodule

// File: tb/test_pf_line_serializer.sv
`timescale 1ns/1ps
module test_pf_line_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic [7:0] hpos = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       p0_px = 1'b0, p1_px = 1'b0;
  logic       pf_px;
  logic [1:0] col_sel;
  logic [7:0] color;

  always #10 clk = ~clk;

  pf_line_serializer i_pf_line_serializer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hpos(hpos),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .p0_px(p0_px), .p1_px(p1_px),
    .pf_px(pf_px), .col_sel(col_sel), .color(color)
  );

  typedef struct {
    logic       pf;
    logic [1:0] sel;
    logic [7:0] col;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  // bench copy of register state, updated from its own writes
  logic [7:0] m_reg [8];
  exp_t       last_exp;

  function automatic logic model_bit(int h);
    int w, k;
    logic [19:0] pat;
    // left-half order per R2
    for (int j = 0; j < 4; j++)  pat[j]      = m_reg[0][4+j];
    for (int j = 0; j < 8; j++)  pat[4+j]    = m_reg[1][7-j];
    for (int j = 0; j < 8; j++)  pat[12+j]   = m_reg[2][j];
    if (h >= 160) return 1'b0;
    w = (h >= 80) ? h - 80 : h;
    k = w / 4;
    if (h >= 80 && m_reg[3][0]) k = 19 - k;   // R4 mirror
    return pat[k];
  endfunction

  function automatic exp_t model(int h, logic a0, logic a1, string tag);
    exp_t e;
    logic on;
    logic [1:0] pfs;
    on = model_bit(h);
    pfs = m_reg[3][1] ? ((h >= 80) ? 2'd3 : 2'd2) : 2'd1;
    if (h >= 160)              e.sel = 2'd0;
    else if (m_reg[3][2] && on) e.sel = pfs;
    else if (a0)               e.sel = 2'd2;
    else if (a1)               e.sel = 2'd3;
    else if (on)               e.sel = pfs;
    else                       e.sel = 2'd0;
    e.pf = on;
    case (e.sel)
      2'd1: e.col = m_reg[5] & 8'hFE;
      2'd2: e.col = m_reg[6] & 8'hFE;
      2'd3: e.col = m_reg[7] & 8'hFE;
      default: e.col = m_reg[4] & 8'hFE;
    endcase
    e.tag = tag;
    return e;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    pix_en = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    m_reg[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pix(input int h, input logic a0, input logic a1, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b0; pix_en = 1'b1; hpos = 8'(h); p0_px = a0; p1_px = a1;
    e = model(h, a0, a1, tag);
    @(posedge clk);
    last_exp = e;
    q.push_back(e);
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic idle(input int h, input logic a0, input logic a1);
    exp_t e;
    @(negedge clk);
    pix_en = 1'b0; hpos = 8'(h); p0_px = a0; p1_px = a1;
    e = last_exp;
    e.tag = "R11 hold";
    @(posedge clk);
    q.push_back(e);
  endtask

  task automatic sweep(input string tag, input int pa, input int pb);
    for (int h = 0; h < 168; h++)
      pix(h, (pa != 0) && (h % pa == 0), (pb != 0) && (h % pb == 1), tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (pf_px !== e.pf || col_sel !== e.sel || color !== e.col) begin
        n_fail++;
        $display("FAIL %s: got pf=%0b sel=%0d col=%02h, expected pf=%0b sel=%0d col=%02h",
                 e.tag, pf_px, col_sel, color, e.pf, e.sel, e.col);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (pf_px !== 1'b0 || col_sel !== 2'd0 || color !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 reset: got pf=%0b sel=%0d col=%02h, expected 0/0/00", pf_px, col_sel, color);
    end
    pix(10, 1'b0, 1'b0, "R1 zero regs");

    wr(3'd4, 8'h5F); wr(3'd5, 8'h3A); wr(3'd6, 8'hC5); wr(3'd7, 8'h87);
    pix(200, 1'b1, 1'b1, "R8 colour lsb");
    wr(3'd0, 8'hA5); wr(3'd1, 8'hC3); wr(3'd2, 8'h81);
    wr(3'd3, 8'h00);
    sweep("R2 R3 repeat", 0, 0);
    wr(3'd3, 8'h01);
    sweep("R4 mirror", 0, 0);
    wr(3'd0, 8'h50); wr(3'd1, 8'h2D); wr(3'd2, 8'h74);
    sweep("R4 mirror b", 0, 0);
    wr(3'd3, 8'h00);
    sweep("R7 players front", 7, 5);
    wr(3'd3, 8'h04);
    sweep("R6 pf front", 7, 5);
    wr(3'd3, 8'h02);
    sweep("R5 score", 11, 3);
    wr(3'd3, 8'h07);
    sweep("R5 R6 score pri", 3, 4);
    for (int h = 160; h < 256; h += 19) pix(h, 1'b1, 1'b1, "R9 offscreen");

    // R10: mid-line write
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h00);
    pix(20, 1'b0, 1'b0, "R10 before write");
    wr(3'd1, 8'hFF);
    pix(21, 1'b0, 1'b0, "R10 after write");
    wr(3'd0, 8'h00);
    pix(2, 1'b0, 1'b0, "R10 pf0 cleared");
    wr(3'd0, 8'hF0);
    pix(3, 1'b0, 1'b0, "R10 pf0 set");
    pix(45, 1'b1, 1'b0, "R7 p0 over pf");
    idle(50, 1'b0, 1'b1);
    idle(200, 1'b1, 1'b0);
    wr(3'd3, 8'h04);
    idle(30, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule